// File: doc/BRIEF.md
# Buffer Status and Interrupt Controller

This block sits between a host register port and a set of packet buffers. It keeps two small state machines per buffer, one for the send direction (host memory to buffer) and one for the receive direction (buffer to host memory). Host register writes start transfers. Host register reads return a snapshot of every buffer's state packed into a single completion word. Events from the buffers and from the data mover change those states.

The send and receive commands carry a buffer index and a length in the address, and a byte address in the write data. When a command is accepted, the block emits a one-cycle transfer request for the data mover. The block raises an interrupt when a buffer gains receive data or when an upload to the host finishes. The host clears the interrupt either through the ready handshake or by reading the status word.

Top module: `bufstat_irq_ctl`

## Requirements
- R1: A synchronous active-high reset puts every send and receive state in the empty state. After reset, irq, cpl_valid and xfer_req are low, and a status read returns all zeros.
- R2: Qword address bits [1:0] (byte address bits [4:3]) select the command: 0 status, 1 send, 2 receive, 3 management. The buffer index is in qword bits [5:2] and the 9-bit length in qword bits [15:7]. A management write issues no transfer request.
- R3: In the status word, buffer n occupies bits [4n+3:4n]. Its send state is in [4n+1:4n] and its receive state in [4n+3:4n+2]. The codes are 0 empty, 1 address known, 2 in transfer, 3 full.
- R4: A read raises cpl_valid on the next cycle. For a status command cpl_data carries the state snapshot; for any other command it carries zero. cpl_valid and cpl_data hold until cpl_done is sampled high, and cpl_valid is low on the following cycle.
- R5: A send write to a buffer whose send state is empty produces, one cycle later, a single-cycle xfer_req with xfer_dir=0, the buffer index, the length and the qword address (write data bits [63:3]). The send state becomes in transfer. A send write to a non-empty send state is ignored.
- R6: An in-transfer send state becomes full when the buffer's accept bit falls. A full send state becomes empty when the accept bit rises. Send-side changes never raise the interrupt.
- R7: A rising valid bit on a buffer whose receive state is empty makes that state full. irq goes high after the second clock edge following the rise.
- R8: A receive write to a buffer whose receive state is full moves it to address known and produces an xfer_req with xfer_dir=1. A receive write in any other receive state is ignored.
- R9: up_start for a buffer in address known moves it to in transfer. up_done for a buffer in transfer moves it to empty and raises irq after the second edge.
- R10: irq is low on the cycle after an edge where irq_rdy is high. A status read accepted while no completion is outstanding clears irq, including an interrupt whose triggering state change that read already observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Host read strobe |
| req_wr | input | 1 | Host write strobe |
| req_qaddr | input | QA_W | Host qword address |
| req_data | input | DATA_W | Host write data (byte address for transfers) |
| cpl_valid | output | 1 | Read completion valid |
| cpl_data | output | DATA_W | Read completion data |
| cpl_done | input | 1 | Completion consumed |
| buf_valid | input | NBUF | Per-buffer receive data present |
| buf_accept | input | NBUF | Per-buffer ready to accept send data |
| up_start | input | 1 | Data mover began an upload |
| up_done | input | 1 | Data mover finished an upload |
| up_bidx | input | BUF_W | Buffer index of up_start / up_done |
| xfer_req | output | 1 | Transfer request pulse |
| xfer_dir | output | 1 | 0 send, 1 receive |
| xfer_bidx | output | BUF_W | Buffer index of request |
| xfer_len | output | LEN_W | Qword length of request |
| xfer_qaddr | output | DATA_W-3 | Qword host address of request |
| irq | output | 1 | Interrupt request |
| irq_rdy | input | 1 | Interrupt taken by the host |

## Verification
A buffer state machine stuck in or skipping a state shows in the next status snapshot, one cycle after the read strobe. It also shows as a missing or extra xfer_req when the next command for that buffer is accepted or refused. A broken event path or irq register shows after the second edge following the triggering input, as a missing, early or stuck interrupt. Every buffer index is walked through the full send and receive lifecycle, so a wrong index decode or nibble placement is caught for every slot.

// File: rtl/bufstat_pkg.sv
package bufstat_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_ADDR  = 2'b01,
        ST_XFER  = 2'b10,
        ST_FULL  = 2'b11
    } slot_st_e;

    typedef enum logic [1:0] {
        CMD_STATUS = 2'b00,
        CMD_SEND   = 2'b01,
        CMD_RECV   = 2'b10,
        CMD_MGMT   = 2'b11
    } cmd_e;

    // qword-address field positions
    localparam int CMD_LSB = 0;
    localparam int BIDX_LSB = 2;
    localparam int LEN_LSB = 7;
    localparam int NIB_W = 4;

    function automatic logic [NIB_W-1:0] pack_nibble(slot_st_e snd, slot_st_e rcv);
        return {rcv, snd};
    endfunction

endpackage

// File: rtl/bufstat_decode.sv
module bufstat_decode
    import bufstat_pkg::*;
#(
    parameter int QA_W  = 16,
    parameter int BUF_W = 4,
    parameter int LEN_W = 9
) (
    input  logic             rd,
    input  logic             wr,
    input  logic [QA_W-1:0]  qaddr,
    output logic             status_rd,
    output logic             any_rd,
    output logic             send_wr,
    output logic             recv_wr,
    output logic [BUF_W-1:0] bidx,
    output logic [LEN_W-1:0] len
);
    cmd_e cmd;

    always_comb begin
        cmd       = cmd_e'(qaddr[CMD_LSB +: 2]);
        bidx      = qaddr[BIDX_LSB +: BUF_W];
        len       = qaddr[LEN_LSB +: LEN_W];
        any_rd    = rd;
        status_rd = rd && (cmd == CMD_STATUS);
        send_wr   = wr && (cmd == CMD_SEND);
        recv_wr   = wr && (cmd == CMD_RECV);
    end
endmodule

// File: rtl/bufstat_slot.sv
module bufstat_slot
    import bufstat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sel_send,
    input  logic     sel_recv,
    input  logic     start_hit,
    input  logic     done_hit,
    input  logic     valid,
    input  logic     accept,
    output slot_st_e snd_st,
    output slot_st_e rcv_st,
    output logic     send_take,
    output logic     recv_take,
    output logic     irq_ev
);
    logic vld_q, acc_q;
    logic v_rise, a_rise, a_fall;

    always_comb begin
        v_rise    = valid && !vld_q;
        a_rise    = accept && !acc_q;
        a_fall    = !accept && acc_q;
        send_take = sel_send && (snd_st == ST_EMPTY);
        recv_take = sel_recv && (rcv_st == ST_FULL);
        irq_ev    = ((rcv_st == ST_EMPTY) && v_rise) ||
                    ((rcv_st == ST_XFER) && done_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            acc_q <= 1'b0;
        end else begin
            vld_q <= valid;
            acc_q <= accept;
        end
    end

    // send direction
    always_ff @(posedge clk) begin
        if (rst) begin
            snd_st <= ST_EMPTY;
        end else begin
            unique case (snd_st)
                ST_EMPTY: if (sel_send) snd_st <= ST_XFER;
                ST_XFER:  if (a_fall)   snd_st <= ST_FULL;
                ST_FULL:  if (a_rise)   snd_st <= ST_EMPTY;
                default:                snd_st <= ST_EMPTY;
            endcase
        end
    end

    // receive direction
    always_ff @(posedge clk) begin
        if (rst) begin
            rcv_st <= ST_EMPTY;
        end else begin
            unique case (rcv_st)
                ST_EMPTY: if (v_rise)    rcv_st <= ST_FULL;
                ST_FULL:  if (sel_recv)  rcv_st <= ST_ADDR;
                ST_ADDR:  if (start_hit) rcv_st <= ST_XFER;
                ST_XFER:  if (done_hit)  rcv_st <= ST_EMPTY;
                default:                 rcv_st <= ST_EMPTY;
            endcase
        end
    end
endmodule

// File: rtl/bufstat_irq.sv
module bufstat_irq (
    input  logic clk,
    input  logic rst,
    input  logic ev,
    input  logic clr_rd,
    input  logic ack,
    output logic evt_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            evt_q <= ev;
            if (clr_rd)
                irq <= 1'b0;
            else if (evt_q)
                irq <= 1'b1;
            else if (ack)
                irq <= 1'b0;
        end
    end
endmodule

// File: rtl/bufstat_irq_ctl.sv
module bufstat_irq_ctl
    import bufstat_pkg::*;
#(
    parameter int NBUF   = 16,
    parameter int QA_W   = 16,
    parameter int DATA_W = 64,
    parameter int LEN_W  = 9,
    localparam int BUF_W = $clog2(NBUF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [QA_W-1:0]   req_qaddr,
    input  logic [DATA_W-1:0] req_data,
    output logic              cpl_valid,
    output logic [DATA_W-1:0] cpl_data,
    input  logic              cpl_done,
    input  logic [NBUF-1:0]   buf_valid,
    input  logic [NBUF-1:0]   buf_accept,
    input  logic              up_start,
    input  logic              up_done,
    input  logic [BUF_W-1:0]  up_bidx,
    output logic              xfer_req,
    output logic              xfer_dir,
    output logic [BUF_W-1:0]  xfer_bidx,
    output logic [LEN_W-1:0]  xfer_len,
    output logic [DATA_W-4:0] xfer_qaddr,
    output logic              irq,
    input  logic              irq_rdy
);
    localparam int STAT_W = NIB_W * NBUF;

    logic             status_rd, any_rd, send_wr, recv_wr;
    logic [BUF_W-1:0] bidx;
    logic [LEN_W-1:0] len;
    slot_st_e         snd_st [NBUF];
    slot_st_e         rcv_st [NBUF];
    logic [NBUF-1:0]  send_take, recv_take, slot_ev;
    logic [DATA_W-1:0] status_word;
    logic             rd_accept;
    logic             evt_q;

    bufstat_decode #(.QA_W(QA_W), .BUF_W(BUF_W), .LEN_W(LEN_W)) u_dec (
        .rd        (req_rd),
        .wr        (req_wr),
        .qaddr     (req_qaddr),
        .status_rd (status_rd),
        .any_rd    (any_rd),
        .send_wr   (send_wr),
        .recv_wr   (recv_wr),
        .bidx      (bidx),
        .len       (len)
    );

    for (genvar i = 0; i < NBUF; i++) begin : g_slot
        bufstat_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .sel_send  (send_wr && (bidx == BUF_W'(i))),
            .sel_recv  (recv_wr && (bidx == BUF_W'(i))),
            .start_hit (up_start && (up_bidx == BUF_W'(i))),
            .done_hit  (up_done && (up_bidx == BUF_W'(i))),
            .valid     (buf_valid[i]),
            .accept    (buf_accept[i]),
            .snd_st    (snd_st[i]),
            .rcv_st    (rcv_st[i]),
            .send_take (send_take[i]),
            .recv_take (recv_take[i]),
            .irq_ev    (slot_ev[i])
        );
    end

    always_comb begin
        status_word = '0;
        for (int i = 0; i < NBUF; i++)
            status_word[NIB_W*i +: NIB_W] = pack_nibble(snd_st[i], rcv_st[i]);
    end

    assign rd_accept = any_rd && !cpl_valid;

    // read completion: snapshot on accept, hold until consumed
    always_ff @(posedge clk) begin
        if (rst) begin
            cpl_valid <= 1'b0;
            cpl_data  <= '0;
        end else if (rd_accept) begin
            cpl_valid <= 1'b1;
            cpl_data  <= status_rd ? status_word : '0;
        end else if (cpl_valid && cpl_done) begin
            cpl_valid <= 1'b0;
        end
    end

    // transfer request toward the data mover
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_req   <= 1'b0;
            xfer_dir   <= 1'b0;
            xfer_bidx  <= '0;
            xfer_len   <= '0;
            xfer_qaddr <= '0;
        end else begin
            xfer_req <= (|send_take) || (|recv_take);
            if ((|send_take) || (|recv_take)) begin
                xfer_dir   <= |recv_take;
                xfer_bidx  <= bidx;
                xfer_len   <= len;
                xfer_qaddr <= req_data[DATA_W-1:3];
            end
        end
    end

    bufstat_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .ev     (|slot_ev),
        .clr_rd (rd_accept && status_rd),
        .ack    (irq_rdy),
        .evt_q  (evt_q),
        .irq    (irq)
    );

    if (STAT_W > DATA_W) begin : g_bad_cfg
        initial $error("status word does not fit completion width");
    end
endmodule

// File: rtl/bufstat_chk.sv
module bufstat_chk #(
    parameter int QA_W   = 16,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_rd,
    input logic              req_wr,
    input logic [QA_W-1:0]   req_qaddr,
    input logic              cpl_valid,
    input logic [DATA_W-1:0] cpl_data,
    input logic              cpl_done,
    input logic              xfer_req,
    input logic              irq,
    input logic              irq_rdy,
    input logic              evt_q
);
    // R4
    cpl_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpl_valid) |-> $past(req_rd));

    // R4
    cpl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && !cpl_done |=> cpl_valid && $stable(cpl_data));

    // R4
    cpl_drop_chk: assert property (@(posedge clk) disable iff (rst)
        cpl_valid && cpl_done |=> !cpl_valid);

    // R5
    xfer_src_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_req |-> $past(req_wr));

    // R10
    irq_ack_chk: assert property (@(posedge clk) disable iff (rst)
        irq && irq_rdy && !evt_q |=> !irq);

    // R10
    irq_rdclr_chk: assert property (@(posedge clk) disable iff (rst)
        req_rd && !cpl_valid && (req_qaddr[1:0] == 2'b00) |=> !irq);

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(evt_q));
endmodule

bind bufstat_irq_ctl bufstat_chk #(.QA_W(QA_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .req_qaddr (req_qaddr),
    .cpl_valid (cpl_valid),
    .cpl_data  (cpl_data),
    .cpl_done  (cpl_done),
    .xfer_req  (xfer_req),
    .irq       (irq),
    .irq_rdy   (irq_rdy),
    .evt_q     (evt_q)
);

// File: tb/bufstat_irq_ctl_tb.sv
module bufstat_irq_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NBUF   = 16;
    localparam int QA_W   = 16;
    localparam int DATA_W = 64;
    localparam int LEN_W  = 9;
    localparam int BUF_W  = 4;
    localparam int WDOG   = 100000;

    logic clk = 1'b0;
    logic rst, req_rd, req_wr, cpl_valid, cpl_done;
    logic [QA_W-1:0]   req_qaddr;
    logic [DATA_W-1:0] req_data, cpl_data;
    logic [NBUF-1:0]   buf_valid, buf_accept;
    logic up_start, up_done, xfer_req, xfer_dir, irq, irq_rdy;
    logic [BUF_W-1:0]  up_bidx, xfer_bidx;
    logic [LEN_W-1:0]  xfer_len;
    logic [DATA_W-4:0] xfer_qaddr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [1:0] m_snd [NBUF];
    logic [1:0] m_rcv [NBUF];

    always #(CLK_PERIOD/2) clk = ~clk;

    bufstat_irq_ctl #(.NBUF(NBUF), .QA_W(QA_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_qaddr(req_qaddr), .req_data(req_data),
        .cpl_valid(cpl_valid), .cpl_data(cpl_data), .cpl_done(cpl_done),
        .buf_valid(buf_valid), .buf_accept(buf_accept),
        .up_start(up_start), .up_done(up_done), .up_bidx(up_bidx),
        .xfer_req(xfer_req), .xfer_dir(xfer_dir), .xfer_bidx(xfer_bidx),
        .xfer_len(xfer_len), .xfer_qaddr(xfer_qaddr),
        .irq(irq), .irq_rdy(irq_rdy)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_word();
        logic [63:0] w = '0;
        for (int i = 0; i < NBUF; i++)
            w[4*i +: 4] = {m_rcv[i], m_snd[i]};
        return w;
    endfunction

    function automatic logic [QA_W-1:0] mk_qaddr(input int cmd, input int b, input int len);
        return QA_W'((len << 7) | (b << 2) | cmd);
    endfunction

    // status read, hold check, then consume
    task automatic status_read();
        logic [63:0] exp_w = model_word();
        req_rd = 1'b1;
        req_qaddr = mk_qaddr(0, 0, 0);
        tick();
        req_rd = 1'b0;
        chk("R4 cpl_valid after read", {63'd0, cpl_valid}, 64'd1);
        chk("R3 status word", cpl_data, exp_w);
        chk("R10 irq cleared by status read", {63'd0, irq}, 64'd0);
        tick();
        chk("R4 cpl held", {63'd0, cpl_valid}, 64'd1);
        chk("R4 cpl data stable", cpl_data, exp_w);
        cpl_done = 1'b1;
        tick();
        cpl_done = 1'b0;
        chk("R4 cpl drops after done", {63'd0, cpl_valid}, 64'd0);
    endtask

    task automatic host_write(input int cmd, input int b, input int len,
                              input logic [60:0] qa, input bit take, input bit dir,
                              input string req);
        req_wr = 1'b1;
        req_qaddr = mk_qaddr(cmd, b, len);
        req_data = {qa, 3'b000};
        tick();
        req_wr = 1'b0;
        chk(req, {63'd0, xfer_req}, {63'd0, take});
        if (take) begin
            chk(req, {63'd0, xfer_dir}, {63'd0, dir});
            chk(req, 64'(xfer_bidx), 64'(b));
            chk(req, 64'(xfer_len), 64'(len));
            chk(req, 64'(xfer_qaddr), 64'(qa));
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_rd = 0; req_wr = 0; req_qaddr = '0; req_data = '0;
        cpl_done = 0; buf_valid = '0; buf_accept = '1;
        up_start = 0; up_done = 0; up_bidx = '0; irq_rdy = 0;
        for (int i = 0; i < NBUF; i++) begin
            m_snd[i] = 2'd0;
            m_rcv[i] = 2'd0;
        end
        repeat (3) tick();
        rst = 1'b0;
        chk("R1 irq reset", {63'd0, irq}, 64'd0);
        chk("R1 cpl_valid reset", {63'd0, cpl_valid}, 64'd0);
        chk("R1 xfer_req reset", {63'd0, xfer_req}, 64'd0);
        tick();
        status_read();

        // management read returns zero, management write does nothing
        req_rd = 1'b1;
        req_qaddr = mk_qaddr(3, 0, 0);
        tick();
        req_rd = 1'b0;
        chk("R4 mgmt read valid", {63'd0, cpl_valid}, 64'd1);
        chk("R4 mgmt read zero", cpl_data, 64'd0);
        cpl_done = 1'b1;
        tick();
        cpl_done = 1'b0;
        host_write(3, 1, 5, 61'h55, 1'b0, 1'b0, "R2 mgmt write ignored");

        for (int b = 0; b < NBUF; b++) begin
            int len = b * 31 + 1;
            logic [60:0] qa = 61'h100 + 61'(b * 3);

            // send lifecycle
            host_write(1, b, len, qa, 1'b1, 1'b0, "R5 send accepted");
            m_snd[b] = 2'd2;
            host_write(1, b, len, qa, 1'b0, 1'b0, "R5 send repeat ignored");
            buf_accept[b] = 1'b0;
            tick();
            m_snd[b] = 2'd3;
            status_read();
            buf_accept[b] = 1'b1;
            tick();
            m_snd[b] = 2'd0;
            tick();
            chk("R6 no irq from send", {63'd0, irq}, 64'd0);

            // receive lifecycle
            host_write(2, b, len, qa, 1'b0, 1'b1, "R8 recv on empty ignored");
            buf_valid[b] = 1'b1;
            tick();
            m_rcv[b] = 2'd3;
            chk("R7 irq not yet", {63'd0, irq}, 64'd0);
            tick();
            chk("R7 irq raised", {63'd0, irq}, 64'd1);
            status_read();
            host_write(2, b, len, qa + 61'd1, 1'b1, 1'b1, "R8 recv accepted");
            m_rcv[b] = 2'd1;
            up_start = 1'b1;
            up_bidx = BUF_W'(b);
            tick();
            up_start = 1'b0;
            m_rcv[b] = 2'd2;
            status_read();
            buf_valid[b] = 1'b0;
            up_done = 1'b1;
            up_bidx = BUF_W'(b);
            tick();
            up_done = 1'b0;
            m_rcv[b] = 2'd0;
            chk("R9 irq not yet", {63'd0, irq}, 64'd0);
            tick();
            chk("R9 irq after upload", {63'd0, irq}, 64'd1);
            irq_rdy = 1'b1;
            tick();
            irq_rdy = 1'b0;
            chk("R10 irq acked", {63'd0, irq}, 64'd0);
            status_read();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule